// File: doc/BRIEF.md
# Byte-to-Pixel Bus Bridge

The bridge sits between a parallel video bus that is either one byte or one 16-bit word wide and a TFT panel pixel port of 16 or 24 bits. On a byte-wide bus it collects successive bytes into one complete pixel. It then issues that pixel with a single-cycle strobe, and it can swap the red and blue channels. On a word-wide bus each word already holds one RGB565 pixel and goes straight through to the output with no register in the way.

Collecting bytes takes a fixed number of cycles in each narrow mode. The upstream sync generator must allow for this delay when it places the first valid pixel of a line. The bridge delays the line and frame syncs by the same number of cycles, so the syncs stay aligned with the pixels. A new line always starts on a pixel boundary, because the active edge of the line sync restarts byte collection. The mode is a static setting and is changed only while reset is held.

Top module: `pix_byte_bridge`

## Requirements
- R1: While reset is asserted in a byte-wide mode, pix_valid is 0 and both sync outputs are at their inactive level (high).
- R2: With mode 0 (and with the reserved mode 3), pix_rgb[15:0] equals bus_data, pix_rgb[23:16] is 0, pix_valid equals bus_valid, and hsync_out and vsync_out equal their inputs in the same cycle.
- R3: With mode 1 (byte-wide RGB565), two valid bytes taken from bus_data[7:0] form one pixel. The first byte becomes bits 15:8 and the second becomes bits 7:0. The pixel appears on pix_rgb[15:0] with pix_valid two cycles after the cycle of its second byte, which is three cycles after its first byte when the two bytes are back to back.
- R4: With mode 2 (byte-wide RGB888), three valid bytes form one pixel, most significant byte first, in bits 23:16, 15:8 and 7:0. The pixel appears three cycles after its last byte, which is five cycles after its first byte when the bytes are back to back.
- R5: With bgr_order high in mode 0, 1 or 3, the output swaps the 5-bit fields 15:11 and 4:0 and leaves green (10:5) unchanged. In the normal order red is 15:11 and blue is 4:0.
- R6: With bgr_order high in mode 2, the output swaps bytes 23:16 and 7:0 and leaves 15:8 unchanged.
- R7: In mode 1, hsync_out and vsync_out repeat their inputs three cycles later. In mode 2 they repeat them five cycles later.
- R8: The cycle in which hsync_in goes from high to low (active low) discards any partially collected pixel, and a valid byte in that cycle is taken as the first byte of a new pixel.
- R9: In byte-wide modes, cycles with bus_valid low neither add a byte nor advance the byte position. pix_valid is high for exactly one cycle per assembled pixel and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0: word-wide RGB565, 1: byte-wide RGB565, 2: byte-wide RGB888, 3: as 0 |
| bgr_order | input | 1 | Swap red and blue channels on output |
| bus_data | input | 16 | Bus word; only bits 7:0 used in byte-wide modes |
| bus_valid | input | 1 | Bus data qualifier |
| hsync_in | input | 1 | Line sync, active low |
| vsync_in | input | 1 | Frame sync, active low |
| pix_rgb | output | 24 | Assembled pixel |
| pix_valid | output | 1 | One-cycle pixel strobe |
| hsync_out | output | 1 | Line sync aligned to pixel output |
| vsync_out | output | 1 | Frame sync aligned to pixel output |

## Verification
The bench runs a reference model of the bridge. From each stimulus it computes in advance the cycle in which each result must appear. A word-wide pixel and its syncs are due in the same cycle as the input. A byte-wide pixel is due two or three cycles after its last byte. Byte-wide syncs are due three or five cycles after they enter. Inputs change on the falling clock edge and outputs are sampled a quarter period before the next rising edge, so every comparison uses the cycle index the model predicted.

// File: rtl/pix_byte_bridge_pkg.sv
package pix_byte_bridge_pkg;

   typedef enum logic [1:0] {
      BUSMODE_WORD565 = 2'd0,
      BUSMODE_BYTE565 = 2'd1,
      BUSMODE_BYTE888 = 2'd2,
      BUSMODE_SPARE   = 2'd3
   } bus_mode_e;

   function automatic logic mode_is_narrow(input logic [1:0] m);
      return (m == BUSMODE_BYTE565) || (m == BUSMODE_BYTE888);
   endfunction

   function automatic logic mode_is_triple(input logic [1:0] m);
      return (m == BUSMODE_BYTE888);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pix_byte_assembler.sv
module pix_byte_assembler #(
   parameter int BYTE_W       = 8,
   parameter bit SYNC_ACT_LOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                narrow,
   input  logic                triple,
   input  logic                hsync,
   input  logic [BYTE_W-1:0]   byte_in,
   input  logic                byte_vld,
   output logic [3*BYTE_W-1:0] asm_word,
   output logic                asm_vld
);
   localparam int PIX_W = 3 * BYTE_W;

   logic [1:0]          ph_q;
   logic                hs_act_prev_q;
   logic [2*BYTE_W-1:0] acc_q;
   logic [PIX_W-1:0]    word_q;
   logic                vld_q;

   logic       hs_act;
   logic       line_start;
   logic [1:0] last_ph;
   logic [1:0] ph_eff;

   assign hs_act     = SYNC_ACT_LOW ? ~hsync : hsync;
   assign line_start = hs_act & ~hs_act_prev_q;
   assign last_ph    = triple ? 2'd2 : 2'd1;
   assign ph_eff     = line_start ? 2'd0 : ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q          <= 2'd0;
         hs_act_prev_q <= 1'b0;
         acc_q         <= '0;
         word_q        <= '0;
         vld_q         <= 1'b0;
      end else begin
         hs_act_prev_q <= hs_act;
         vld_q         <= 1'b0;
         if (!narrow) begin
            ph_q <= 2'd0;
         end else if (byte_vld) begin
            acc_q <= {acc_q[BYTE_W-1:0], byte_in};
            if (ph_eff == last_ph) begin
               ph_q  <= 2'd0;
               vld_q <= 1'b1;
               if (triple)
                  word_q <= {acc_q, byte_in};
               else
                  word_q <= {{BYTE_W{1'b0}}, acc_q[BYTE_W-1:0], byte_in};
            end else begin
               ph_q <= ph_eff + 2'd1;
            end
         end else begin
            ph_q <= ph_eff;
         end
      end
   end

   assign asm_word = word_q;
   assign asm_vld  = vld_q;

   // R9
   asm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);

   // R8
   line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && line_start) |=> !vld_q);

   // R4
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q <= (triple ? 2'd2 : 2'd1));

endmodule

// File: rtl/pix_tap_delay.sv
module pix_tap_delay #(
   parameter int             W       = 8,
   parameter int             DEPTH   = 2,
   parameter logic [W-1:0]   RST_VAL = '0,
   localparam int            SEL_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout
);
   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   logic [W-1:0] tap [DEPTH+1];
   assign tap[0] = din;
   for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      assign tap[g+1] = stage_q[g];
   end

   always_comb begin
      dout = din;
      for (int i = 1; i <= DEPTH; i++)
         if (sel == SEL_W'(i)) dout = tap[i];
   end

   // R7
   tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel <= SEL_W'(DEPTH));

endmodule

// File: rtl/pix_chan_order.sv
module pix_chan_order #(
   parameter int BYTE_W = 8
) (
   input  logic                triple,
   input  logic                bgr,
   input  logic [3*BYTE_W-1:0] din,
   output logic [3*BYTE_W-1:0] dout
);
   localparam int B = BYTE_W;

   logic [3*B-1:0] sw888;
   logic [3*B-1:0] sw565;

   assign sw888 = {din[B-1:0], din[2*B-1:B], din[3*B-1:2*B]};
   assign sw565 = {din[3*B-1:2*B], din[4:0], din[10:5], din[15:11]};

   always_comb begin
      if (!bgr)
         dout = din;
      else if (triple)
         dout = sw888;
      else
         dout = sw565;
   end

endmodule

// File: rtl/pix_byte_bridge.sv
module pix_byte_bridge #(
   parameter int BYTE_W       = 8,
   parameter int LAT_565      = 3,
   parameter int LAT_888      = 5,
   parameter bit SYNC_ACT_LOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic                bgr_order,
   input  logic [2*BYTE_W-1:0] bus_data,
   input  logic                bus_valid,
   input  logic                hsync_in,
   input  logic                vsync_in,
   output logic [3*BYTE_W-1:0] pix_rgb,
   output logic                pix_valid,
   output logic                hsync_out,
   output logic                vsync_out
);
   import pix_byte_bridge_pkg::*;

   localparam int PIX_W      = 3 * BYTE_W;
   localparam int DATA_DEPTH = imax(imax(LAT_565 - 2, LAT_888 - 3), 1);
   localparam int SYNC_DEPTH = imax(LAT_565, LAT_888);
   localparam int DSEL_W     = $clog2(DATA_DEPTH + 1);
   localparam int SSEL_W     = $clog2(SYNC_DEPTH + 1);
   localparam logic [DSEL_W-1:0] DSEL_565 = DSEL_W'(LAT_565 - 2);
   localparam logic [DSEL_W-1:0] DSEL_888 = DSEL_W'(LAT_888 - 3);
   localparam logic [SSEL_W-1:0] SSEL_565 = SSEL_W'(LAT_565);
   localparam logic [SSEL_W-1:0] SSEL_888 = SSEL_W'(LAT_888);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("pix_byte_bridge: RGB565 field split needs BYTE_W of 8");
   end
   if (LAT_565 < 2) begin : g_bad_lat565
      $error("pix_byte_bridge: LAT_565 below the two-byte assembly time");
   end
   if (LAT_888 < 3) begin : g_bad_lat888
      $error("pix_byte_bridge: LAT_888 below the three-byte assembly time");
   end

   logic narrow;
   logic triple;
   assign narrow = mode_is_narrow(mode);
   assign triple = mode_is_triple(mode);

   logic [PIX_W-1:0] asm_word;
   logic             asm_vld;

   pix_byte_assembler #(
      .BYTE_W       (BYTE_W),
      .SYNC_ACT_LOW (SYNC_ACT_LOW)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .narrow   (narrow),
      .triple   (triple),
      .hsync    (hsync_in),
      .byte_in  (bus_data[BYTE_W-1:0]),
      .byte_vld (bus_valid),
      .asm_word (asm_word),
      .asm_vld  (asm_vld)
   );

   logic [PIX_W:0] dly_data;

   pix_tap_delay #(
      .W       (PIX_W + 1),
      .DEPTH   (DATA_DEPTH),
      .RST_VAL ('0)
   ) u_data_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({asm_vld, asm_word}),
      .sel   (triple ? DSEL_888 : DSEL_565),
      .dout  (dly_data)
   );

   logic [1:0] dly_sync;

   pix_tap_delay #(
      .W       (2),
      .DEPTH   (SYNC_DEPTH),
      .RST_VAL ({2{SYNC_ACT_LOW}})
   ) u_sync_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({hsync_in, vsync_in}),
      .sel   (triple ? SSEL_888 : SSEL_565),
      .dout  (dly_sync)
   );

   logic [PIX_W-1:0] raw_pix;

   always_comb begin
      if (narrow) begin
         raw_pix   = dly_data[PIX_W-1:0];
         pix_valid = dly_data[PIX_W];
         hsync_out = dly_sync[1];
         vsync_out = dly_sync[0];
      end else begin
         raw_pix   = {{BYTE_W{1'b0}}, bus_data};
         pix_valid = bus_valid;
         hsync_out = hsync_in;
         vsync_out = vsync_in;
      end
   end

   pix_chan_order #(
      .BYTE_W (BYTE_W)
   ) u_order (
      .triple (triple),
      .bgr    (bgr_order),
      .din    (raw_pix),
      .dout   (pix_rgb)
   );

   // R9
   pix_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && pix_valid) |=> (!pix_valid || !narrow));

endmodule

// File: tb/pix_byte_bridge_tb.sv
module pix_byte_bridge_tb;
   localparam int NMAX = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd1;
   logic        bgr_order = 1'b0;
   logic [15:0] bus_data = '0;
   logic        bus_valid = 1'b0;
   logic        hsync_in = 1'b1;
   logic        vsync_in = 1'b1;
   logic [23:0] pix_rgb;
   logic        pix_valid;
   logic        hsync_out;
   logic        vsync_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pix_byte_bridge u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .bgr_order (bgr_order),
      .bus_data  (bus_data),
      .bus_valid (bus_valid),
      .hsync_in  (hsync_in),
      .vsync_in  (vsync_in),
      .pix_rgb   (pix_rgb),
      .pix_valid (pix_valid),
      .hsync_out (hsync_out),
      .vsync_out (vsync_out)
   );

   logic [15:0] st_d  [NMAX];
   bit          st_v  [NMAX];
   bit          st_hs [NMAX];
   bit          st_vs [NMAX];
   bit          exp_v [NMAX+8];
   logic [23:0] exp_d [NMAX+8];

   function automatic logic [23:0] fmt_pix(input logic [1:0] m, input bit bgr,
                                           input logic [23:0] raw);
      logic [15:0] w;
      w = raw[15:0];
      if (m == 2'd2) return bgr ? {raw[7:0], raw[15:8], raw[23:16]} : raw;
      return bgr ? {8'h00, w[4:0], w[10:5], w[15:11]} : {8'h00, w};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic fill_rand(input int n, input bit contiguous);
      for (int k = 0; k < n; k++) begin
         bit idle;
         idle     = (k >= n - 8);
         st_v[k]  = idle ? 1'b0 : (contiguous ? 1'b1 : (($urandom % 4) != 0));
         st_d[k]  = 16'($urandom);
         st_hs[k] = idle ? 1'b1 : ((k % 37) >= 2);
         st_vs[k] = idle ? 1'b1 : ((k % 150) >= 3);
      end
   endtask

   task automatic fill_idle(input int n);
      for (int k = 0; k < n; k++) begin
         st_v[k] = 1'b0; st_d[k] = 16'($urandom); st_hs[k] = 1'b1; st_vs[k] = 1'b1;
      end
   endtask

   task automatic put(input int k, input bit hs, input logic [7:0] b);
      st_v[k] = 1'b1; st_hs[k] = hs; st_d[k] = {8'hA5, b};
   endtask

   task automatic run_seg(input string tag, input logic [1:0] m, input bit bgr, input int n);
      bit   narrow, prev_act, act;
      int   ph, last, dpix, lat;
      logic [23:0] acc;
      string stag;
      narrow = (m == 2'd1) || (m == 2'd2);
      last   = (m == 2'd2) ? 2 : 1;
      dpix   = (m == 2'd2) ? 3 : 2;
      lat    = (m == 2'd2) ? 5 : 3;
      stag   = narrow ? "R7" : "R2";
      for (int k = 0; k < NMAX + 8; k++) begin exp_v[k] = 1'b0; exp_d[k] = '0; end
      ph = 0; prev_act = 1'b0; acc = '0;
      for (int k = 0; k < n; k++) begin
         if (narrow) begin
            act = !st_hs[k];
            if (act && !prev_act) ph = 0;
            prev_act = act;
            if (st_v[k]) begin
               acc = {acc[15:0], st_d[k][7:0]};
               if (ph == last) begin
                  exp_v[k+dpix] = 1'b1;
                  exp_d[k+dpix] = fmt_pix(m, bgr, acc);
                  ph = 0;
               end else ph++;
            end
         end else begin
            exp_v[k] = st_v[k];
            exp_d[k] = fmt_pix(m, bgr, {8'h00, st_d[k]});
         end
      end
      @(negedge clk);
      rst_n = 1'b0; mode = m; bgr_order = bgr; bus_valid = 1'b0;
      hsync_in = 1'b1; vsync_in = 1'b1;
      repeat (2) @(posedge clk);
      for (int k = 0; k < n; k++) begin
         bit ehs, evs;
         @(negedge clk);
         rst_n = 1'b1;
         bus_valid = st_v[k]; bus_data = st_d[k];
         hsync_in = st_hs[k]; vsync_in = st_vs[k];
         #5;
         chk(tag, "pix_valid", {23'd0, pix_valid}, {23'd0, exp_v[k]});
         if (exp_v[k]) chk(tag, "pix_rgb", pix_rgb, exp_d[k]);
         if (narrow) begin
            ehs = (k >= lat) ? st_hs[k-lat] : 1'b1;
            evs = (k >= lat) ? st_vs[k-lat] : 1'b1;
         end else begin
            ehs = st_hs[k]; evs = st_vs[k];
         end
         chk(stag, "hsync_out", {23'd0, hsync_out}, {23'd0, ehs});
         chk(stag, "vsync_out", {23'd0, vsync_out}, {23'd0, evs});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state with active inputs in a byte-wide mode
      rst_n = 1'b0; mode = 2'd1; bus_valid = 1'b1; bus_data = 16'hFFFF;
      hsync_in = 1'b0; vsync_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "pix_valid", {23'd0, pix_valid}, 24'd0);
      chk("R1", "hsync_out", {23'd0, hsync_out}, 24'd1);
      chk("R1", "vsync_out", {23'd0, vsync_out}, 24'd1);

      fill_rand(120, 1'b0); run_seg("R2", 2'd0, 1'b0, 120);
      fill_rand(120, 1'b0); run_seg("R5", 2'd0, 1'b1, 120);
      fill_rand(80, 1'b0);  run_seg("R2", 2'd3, 1'b0, 80);
      fill_rand(60, 1'b1);  run_seg("R3", 2'd1, 1'b0, 60);
      fill_rand(300, 1'b0); run_seg("R9", 2'd1, 1'b0, 300);
      fill_rand(200, 1'b0); run_seg("R5", 2'd1, 1'b1, 200);
      fill_rand(60, 1'b1);  run_seg("R4", 2'd2, 1'b0, 60);
      fill_rand(300, 1'b0); run_seg("R9", 2'd2, 1'b0, 300);
      fill_rand(200, 1'b0); run_seg("R6", 2'd2, 1'b1, 200);

      // R8: partial RGB565 pixel discarded at a line edge
      fill_idle(30);
      put(3, 1'b1, 8'h11);
      put(4, 1'b0, 8'h22);
      put(5, 1'b0, 8'h33);
      put(7, 1'b1, 8'h44);
      put(9, 1'b1, 8'h55);
      run_seg("R8", 2'd1, 1'b0, 30);

      // R8: two stray RGB888 bytes discarded at a line edge
      fill_idle(30);
      put(3, 1'b1, 8'hA1);
      put(4, 1'b1, 8'hB2);
      put(5, 1'b0, 8'hC3);
      put(6, 1'b0, 8'hD4);
      put(7, 1'b1, 8'hE5);
      put(8, 1'b1, 8'hF6);
      put(10, 1'b1, 8'h07);
      put(12, 1'b1, 8'h18);
      run_seg("R8", 2'd2, 1'b0, 30);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule